// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block picks a sampling-clock tap after a tuning sweep. Each probe of a tap gives a pass or fail bit. The caller supplies a bitmap holding two consecutive sweeps over the N taps, for 2×N bits in all. Because the two sweeps sit end to end, a passing window that wraps from the last tap to tap 0 shows up as one unbroken run.

After a start request, the block walks the bitmap one bit per clock. It keeps the length and limits of the run of passes now in progress, and of the best run found so far. At the end of the walk it reports the centre of the best run, folded back into the range 0..N-1. If no run of passes is long enough, it reports an error instead.

Running the probes and programming the delay line are left to the surrounding logic.

Top module: `tapwin_select`

## Requirements
- R1: After reset, done, valid and error are 0 and tap is 0.
- R2: Bit i of probe_map is the result of probe i, and 1 means pass. Only bits 0 to 2N-1 are examined, and higher bits have no effect. A tap_count above 16 is treated as 16.
- R3: The chosen run is the longest run of consecutive pass bits within the examined range.
- R4: When several runs share the greatest length, the one that starts at the lowest index is chosen.
- R5: A run that reaches bit 2N-1 takes part in the comparison like any other run.
- R6: If the longest run is shorter than 3, the result is error=1, valid=0 and tap=0. Otherwise the result is valid=1 and error=0.
- R7: For a chosen run from index s to index e, tap equals ((s+e) div 2) mod N.
- R8: If start is accepted at clock edge k, done is high for exactly one cycle, after edge k+2N+1. Valid, error and tap keep their values until the next accepted start, which clears them at its edge.
- R9: A start request that arrives while a scan or its closing cycle is in progress is ignored. It does not change that scan's result or timing.
- R10: With tap_count 0, the block reports error one cycle after the start edge (the R8 timing with N=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a scan; accepted only when idle |
| probe_map | input | 32 | Probe results, bit i = probe i, 1 = pass |
| tap_count | input | 5 | Number of taps N (0..16) |
| done | output | 1 | One-cycle pulse when a result is ready |
| valid | output | 1 | Result holds a chosen tap |
| tap | output | 4 | Chosen tap index |
| error | output | 1 | No run of at least 3 passes was found |

## Verification
Every bitmap is swept exhaustively for N=3 and N=4. These sweeps separate the rules on run length, ties, open trailing runs and wrap-around folding from one another. Directed maps cover the remaining cases:
- two equally long runs, which exposes a latest-wins tie rule;
- a window that crosses from the first sweep into the second, which checks the fold to 0;
- runs of exactly 2 and exactly 3, on either side of the threshold;
- set bits above 2N, which must be ignored.

Random maps at every N from 1 to 16 check the 2N+1 latency and the result at full width. Start pulses sent mid-scan must leave the result and its timing unchanged.

// File: rtl/tapwin_pkg.sv
package tapwin_pkg;
    localparam int MAX_TAPS = 16;
    localparam int MAP_W    = 2 * MAX_TAPS;
    localparam int IDX_W    = $clog2(MAP_W + 1);
    localparam int POS_W    = $clog2(MAP_W);
    localparam int TAP_W    = $clog2(MAX_TAPS);
    localparam int CNT_W    = $clog2(MAX_TAPS + 1);
    localparam int MIN_RUN  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CLOSE = 2'd2
    } scan_st_t;

    typedef struct packed {
        logic [IDX_W-1:0] len;
        logic [POS_W-1:0] first;
        logic [POS_W-1:0] last;
    } run_t;

    // Centre of a run, folded into 0..n-1; the centre is always below 2n.
    function automatic logic [TAP_W-1:0] centre_fold(input logic [POS_W-1:0] first,
                                                     input logic [POS_W-1:0] last,
                                                     input logic [CNT_W-1:0] n);
        logic [POS_W:0]   sum;
        logic [POS_W-1:0] mid;
        logic [POS_W-1:0] folded;
        sum    = {1'b0, first} + {1'b0, last};
        mid    = sum[POS_W:1];
        folded = ({1'b0, mid} >= {{(POS_W + 1 - CNT_W){1'b0}}, n}) ?
                 mid - POS_W'(n) : mid;
        return folded[TAP_W-1:0];
    endfunction
endpackage

// File: rtl/tapwin_ctrl.sv
module tapwin_ctrl
    import tapwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MAP_W-1:0] map_in,
    input  logic [CNT_W-1:0] n_in,
    output scan_st_t         state,
    output logic [IDX_W-1:0] idx,
    output logic             bit_now,
    output logic [CNT_W-1:0] n_q,
    output logic             accept
);
    logic [MAP_W-1:0] map_q;
    logic [CNT_W-1:0] n_eff;
    logic [IDX_W-1:0] span;

    assign accept  = start && (state == ST_IDLE);
    assign n_eff   = (n_in > CNT_W'(MAX_TAPS)) ? CNT_W'(MAX_TAPS) : n_in;
    assign span    = IDX_W'(n_q) << 1;
    assign bit_now = map_q[idx[POS_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            map_q <= '0;
            n_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    map_q <= map_in;
                    n_q   <= n_eff;
                    idx   <= '0;
                    state <= (n_eff == '0) ? ST_CLOSE : ST_SCAN;
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (idx == span - 1'b1) state <= ST_CLOSE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> ($stable(map_q) && $stable(n_q)));

    p_scan_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN) |-> (idx < span));
endmodule

// File: rtl/tapwin_track.sv
module tapwin_track
    import tapwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_now,
    input  logic [IDX_W-1:0] idx,
    output run_t             final_best
);
    logic [IDX_W-1:0] cur_len;
    run_t             best;
    run_t             cand;
    logic             take;

    always_comb begin
        cand.len   = cur_len;
        cand.first = POS_W'(idx - cur_len);
        cand.last  = POS_W'(idx - 1'b1);
        take       = cur_len > best.len;
        final_best = take ? cand : best;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur_len <= '0;
            best    <= '0;
        end else if (step) begin
            if (bit_now) begin
                cur_len <= cur_len + 1'b1;
            end else begin
                if (take) best <= cand;
                cur_len <= '0;
            end
        end
    end

    p_best_grows_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (best.len >= $past(best.len)));

    p_run_fits_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> (cur_len <= idx));
endmodule

// File: rtl/tapwin_report.sv
module tapwin_report
    import tapwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             close,
    input  run_t             final_best,
    input  logic [CNT_W-1:0] n_q,
    output logic             done,
    output logic             valid,
    output logic             error,
    output logic [TAP_W-1:0] tap
);
    logic long_enough;
    assign long_enough = final_best.len >= IDX_W'(MIN_RUN);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            done  <= 1'b0;
            valid <= 1'b0;
            error <= 1'b0;
            tap   <= '0;
        end else if (close) begin
            done  <= 1'b1;
            valid <= long_enough;
            error <= !long_enough;
            tap   <= long_enough ? centre_fold(final_best.first, final_best.last, n_q) : '0;
        end else begin
            done <= 1'b0;
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clear && !close) |=> ($stable(valid) && $stable(error) && $stable(tap)));

    p_tap_below_n_r7: assert property (@(posedge clk) disable iff (rst)
        valid |-> ({1'b0, tap} < n_q));

    p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (valid != error));
endmodule

// File: rtl/tapwin_select.sv
module tapwin_select
    import tapwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MAP_W-1:0] probe_map,
    input  logic [CNT_W-1:0] tap_count,
    output logic             done,
    output logic             valid,
    output logic [TAP_W-1:0] tap,
    output logic             error
);
    scan_st_t         state;
    logic [IDX_W-1:0] idx;
    logic             bit_now;
    logic [CNT_W-1:0] n_q;
    logic             accept;
    run_t             final_best;

    tapwin_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .map_in  (probe_map),
        .n_in    (tap_count),
        .state   (state),
        .idx     (idx),
        .bit_now (bit_now),
        .n_q     (n_q),
        .accept  (accept)
    );

    tapwin_track u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .step       (state == ST_SCAN),
        .bit_now    (bit_now),
        .idx        (idx),
        .final_best (final_best)
    );

    tapwin_report u_report (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .close      (state == ST_CLOSE),
        .final_best (final_best),
        .n_q        (n_q),
        .done       (done),
        .valid      (valid),
        .error      (error),
        .tap        (tap)
    );

    p_short_run_fails_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLOSE && final_best.len < IDX_W'(MIN_RUN)) |=> (error && !valid));
endmodule

// File: tb/sim_tapwin_select.sv
module sim_tapwin_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] probe_map = '0;
    logic [4:0]  tap_count = '0;
    logic        done, valid, error;
    logic [3:0]  tap;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tapwin_select u0 (
        .clk(clk), .rst(rst), .start(start), .probe_map(probe_map),
        .tap_count(tap_count), .done(done), .valid(valid), .tap(tap), .error(error)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result computed from the requirement text.
    task automatic expect_of(input logic [31:0] m, input int n, output bit ok, output int t);
        int best = 0, cur = 0, bs = 0, be = 0;
        for (int i = 0; i < 2 * n; i++) begin
            if (m[i]) cur++;
            else begin
                if (cur > best) begin bs = i - cur; be = i - 1; best = cur; end
                cur = 0;
            end
        end
        if (cur > best) begin bs = 2 * n - cur; be = 2 * n - 1; best = cur; end
        ok = (best >= 3);
        t  = ok ? ((bs + be) / 2) % n : 0;
    endtask

    task automatic run(input string req, input logic [31:0] m, input int n,
                       input bit poke, input logic [31:0] m2, input bit hold);
        int  neff = (n > 16) ? 16 : n;
        bit  ok;
        int  t;
        int  k = 0;
        bit  got = 0;
        expect_of(m, neff, ok, t);
        @(posedge clk); #1;
        start = 1'b1; probe_map = m; tap_count = 5'(n);
        while (k < 80 && !got) begin
            @(posedge clk); #1;
            k++;
            if (k == 1) start = 1'b0;
            if (poke && k == 3) begin start = 1'b1; probe_map = m2; tap_count = 5'd1; end
            if (poke && k == 4) start = 1'b0;
            if (done) got = 1;
        end
        chk("R8 latency", k, 2 * neff + 2);
        chk({req, " valid"}, int'(valid), int'(ok));
        chk({req, " R6 error"}, int'(error), int'(!ok));
        chk({req, " R7 tap"}, int'(tap), t);
        if (hold) begin
            repeat (3) @(posedge clk);
            #1;
            chk("R8 done pulse", int'(done), 0);
            chk("R8 hold valid", int'(valid), int'(ok));
            chk("R8 hold tap", int'(tap), t);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 done", int'(done), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 tap", int'(tap), 0);
        rst = 1'b0;

        run("R10 zero taps", 32'hFFFF_FFFF, 0, 0, 0, 1);
        for (int m = 0; m < 64; m++)  run("R3 sweep n3", 32'(m), 3, 0, 0, 0);
        for (int m = 0; m < 256; m++) run("R3 sweep n4", 32'(m), 4, 0, 0, 0);
        run("R4 tie earliest", 32'h0000_03DE, 8, 0, 0, 1);
        run("R5 open end run", 32'h0000_00E3, 4, 0, 0, 0);
        run("R7 wrap fold", 32'h0000_07C0, 8, 0, 0, 0);
        run("R7 all pass n16", 32'hFFFF_FFFF, 16, 0, 0, 0);
        run("R6 run of two", 32'h0000_0006, 8, 0, 0, 0);
        run("R6 run of three", 32'h0000_000E, 8, 0, 0, 0);
        run("R2 high bits", 32'hFFFF_FFC0, 3, 0, 0, 0);
        run("R2 count clamp", 32'hFFFF_FFFF, 20, 0, 0, 0);
        run("R9 busy start", 32'h0000_001C, 6, 1, 32'hFFFF_FFFF, 1);
        run("R9 busy start n1", 32'h0000_0000, 1, 1, 32'hFFFF_FFFF, 0);
        for (int r = 0; r < 300; r++)
            run("R3 random", $urandom, 1 + (r % 16), 0, 0, (r % 10) == 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule